// File: doc/BRIEF.md
# Condition Flag and Branch Resolver

This block holds the three condition flags of a small 16-bit processor core (negative, zero, positive) and resolves conditional branches. On each clock edge on which the core writes a result back and the instruction in flight belongs to the flag-setting class, the block classifies that result by sign and zero-ness. The classification is registered as the new flag state. All other instructions leave the flags as they were.

The branch side is combinational. When the current instruction word carries the branch opcode, its three-bit test mask is compared with the registered flags. The block then reports whether the branch is taken, the target address, and the program counter to use next. The target is the already-incremented PC plus the sign-extended 9-bit offset, so branches in both directions are covered. Register file access, memory, and the core's other redirections (register jump, service call) stay outside the block.

Top module: `ccBranchUnit`

## Requirements
- R1: After reset the flag output `flags` is 3'b010. Bit 2 is N, bit 1 is Z and bit 0 is P.
- R2: A written result whose bit 15 is 1 sets flags to 3'b100. A result equal to 16'h0000 sets 3'b010. Any other result sets 3'b001. Exactly one flag is ever set.
- R3: The flags take the new value at the clock edge on which `loadEn` is 1 and instr[15:12] is one of 4'b0001, 4'b0101, 4'b1001, 4'b0010, 4'b0110, 4'b1010 or 4'b1110.
- R4: When `loadEn` is 0, or when the opcode is any value outside the R3 set, the flags keep their value across the edge. This includes stores, branch, jump, service call and the reserved code.
- R5: When instr[15:12] is 4'b0000, `brTaken` is 1 in the same cycle if and only if (instr[11:9] & flags) is nonzero. Bit 11 tests N, bit 10 tests Z and bit 9 tests P. Mask 3'b111 is therefore always taken and mask 3'b000 is never taken.
- R6: When instr[15:12] is not 4'b0000, `brTaken` is 0 whatever the other bits hold.
- R7: `brTarget` equals pcInc plus instr[8:0] sign-extended to 16 bits, modulo 2^16. An offset of 9'h0FF gives +255, 9'h100 gives -256 and 9'h1FA gives -6.
- R8: `nextPc` equals `brTarget` when `brTaken` is 1 and `pcInc` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | A result is being written back this cycle |
| wbResult | input | 16 | Value being written back |
| instr | input | 16 | Current instruction word |
| pcInc | input | 16 | Incremented program counter |
| flags | output | 3 | Registered {N, Z, P} |
| brTaken | output | 1 | Conditional branch is taken |
| brTarget | output | 16 | pcInc plus the sign-extended offset |
| nextPc | output | 16 | Selected next program counter |

## Verification
A corrupted flag register does not show directly as a wrong PC. It shows up the first time a branch presents a mask that discriminates the wrong state from the right one. That can be several instructions after the faulty write, so the bench places a branch immediately after every flag write and sweeps all eight masks. A gating error in the opcode decode shows one edge later, as a flag that moved when it should have held. A sign-extension fault shows in the same cycle on `brTarget`, but only for offsets with bit 8 set. The bench therefore probes both extremes of the offset range.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int DATA_W = 16;
  localparam int OFF_W  = 9;
  localparam int OPC_W  = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_BR   = 4'b0000,
    OP_ADD  = 4'b0001,
    OP_LD   = 4'b0010,
    OP_ST   = 4'b0011,
    OP_AND  = 4'b0101,
    OP_LDR  = 4'b0110,
    OP_STR  = 4'b0111,
    OP_NOT  = 4'b1001,
    OP_LDI  = 4'b1010,
    OP_STI  = 4'b1011,
    OP_JMP  = 4'b1100,
    OP_RSV  = 4'b1101,
    OP_LEA  = 4'b1110,
    OP_TRAP = 4'b1111
  } opcode_e;

  // flag encoding {N, Z, P}
  localparam logic [2:0] FLAG_N = 3'b100;
  localparam logic [2:0] FLAG_Z = 3'b010;
  localparam logic [2:0] FLAG_P = 3'b001;

  typedef struct packed {
    logic flagWrite;
    logic isBranch;
  } ctrlStrobes_t;
endpackage

// File: rtl/ccControl.sv
module ccControl
  import cc_pkg::*;
#(
  parameter int OPCW = OPC_W
) (
  input  logic            loadEn,
  input  logic [OPCW-1:0] opcode,
  output ctrlStrobes_t    strobes
);
  logic setsFlags;

  always_comb begin
    unique case (opcode)
      OP_ADD, OP_AND, OP_NOT, OP_LD, OP_LDR, OP_LDI, OP_LEA: setsFlags = 1'b1;
      default:                                               setsFlags = 1'b0;
    endcase
  end

  always_comb begin
    strobes.flagWrite = loadEn & setsFlags;
    strobes.isBranch  = (opcode == OP_BR);
  end
endmodule

// File: rtl/ccDatapath.sv
module ccDatapath
  import cc_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int OFFW = OFF_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic [DW-1:0] wbResult,
  input  logic [2:0]    testMask,
  input  logic [OFFW-1:0] offset,
  input  logic [DW-1:0] pcInc,
  output logic [2:0]    flags,
  output logic          brTaken,
  output logic [DW-1:0] brTarget,
  output logic [DW-1:0] nextPc
);
  localparam int EXT_W = DW - OFFW;

  logic [2:0]    newFlags;
  logic [DW-1:0] offsetExt;

  always_comb begin
    if (wbResult[DW-1])      newFlags = FLAG_N;
    else if (wbResult == '0) newFlags = FLAG_Z;
    else                     newFlags = FLAG_P;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flags <= FLAG_Z;
    else if (strobes.flagWrite) flags <= newFlags;
  end

  generate
    if (EXT_W > 0) begin : g_ext
      assign offsetExt = {{EXT_W{offset[OFFW-1]}}, offset};
    end else begin : g_trunc
      assign offsetExt = offset[DW-1:0];
    end
  endgenerate

  always_comb begin
    brTarget = pcInc + offsetExt;
    brTaken  = strobes.isBranch && ((testMask & flags) != 3'b000);
    nextPc   = brTaken ? brTarget : pcInc;
  end
endmodule

// File: rtl/ccBranchUnit.sv
module ccBranchUnit
  import cc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadEn,
  input  logic [15:0] wbResult,
  input  logic [15:0] instr,
  input  logic [15:0] pcInc,
  output logic [2:0]  flags,
  output logic        brTaken,
  output logic [15:0] brTarget,
  output logic [15:0] nextPc
);
  ctrlStrobes_t strobes;

  ccControl #(.OPCW(OPC_W)) u_ctrl (
    .loadEn  (loadEn),
    .opcode  (instr[15:12]),
    .strobes (strobes)
  );

  ccDatapath #(.DW(DATA_W), .OFFW(OFF_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wbResult (wbResult),
    .testMask (instr[11:9]),
    .offset   (instr[OFF_W-1:0]),
    .pcInc    (pcInc),
    .flags    (flags),
    .brTaken  (brTaken),
    .brTarget (brTarget),
    .nextPc   (nextPc)
  );
endmodule

// File: rtl/ccBranchChecker.sv
module ccBranchChecker (
  input logic        clk,
  input logic        rstN,
  input logic        loadEn,
  input logic [15:0] wbResult,
  input logic [15:0] instr,
  input logic [15:0] pcInc,
  input logic [2:0]  flags,
  input logic        brTaken,
  input logic [15:0] brTarget,
  input logic [15:0] nextPc
);
  logic addWrite;
  logic quietOp;
  assign addWrite = loadEn && (instr[15:12] == 4'b0001);
  assign quietOp  = (instr[15:12] == 4'b0011) || (instr[15:12] == 4'b0111) ||
                    (instr[15:12] == 4'b0000) || (instr[15:12] == 4'b1111);

  // R2
  a_r2_one_flag: assert property (@(posedge clk) disable iff (!rstN)
    $countones(flags) == 1);

  // R3
  a_r3_neg_result: assert property (@(posedge clk) disable iff (!rstN)
    addWrite && wbResult[15] |=> flags == 3'b100);
  a_r3_zero_result: assert property (@(posedge clk) disable iff (!rstN)
    addWrite && (wbResult == 16'h0000) |=> flags == 3'b010);

  // R4
  a_r4_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(flags));
  a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rstN)
    quietOp |=> $stable(flags));

  // R5
  a_r5_always: assert property (@(posedge clk) disable iff (!rstN)
    instr[15:9] == 7'b0000111 |-> brTaken);
  a_r5_never: assert property (@(posedge clk) disable iff (!rstN)
    instr[15:9] == 7'b0000000 |-> !brTaken);

  // R6
  a_r6_not_branch: assert property (@(posedge clk) disable iff (!rstN)
    instr[15:12] != 4'b0000 |-> !brTaken);

  // R8
  a_r8_select: assert property (@(posedge clk) disable iff (!rstN)
    nextPc == (brTaken ? brTarget : pcInc));
endmodule

bind ccBranchUnit ccBranchChecker u_chk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .wbResult(wbResult),
  .instr(instr), .pcInc(pcInc), .flags(flags), .brTaken(brTaken),
  .brTarget(brTarget), .nextPc(nextPc)
);

// File: tb/tb_ccBranchUnit.sv
module tb_ccBranchUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [15:0] wbResult = '0;
  logic [15:0] instr = '0;
  logic [15:0] pcInc = 16'h3000;
  logic [2:0]  flags;
  logic        brTaken;
  logic [15:0] brTarget;
  logic [15:0] nextPc;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ccBranchUnit dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .wbResult(wbResult),
    .instr(instr), .pcInc(pcInc), .flags(flags), .brTaken(brTaken),
    .brTarget(brTarget), .nextPc(nextPc)
  );

  // {result[15:0], mask[2:0], expectedTaken}
  localparam logic [19:0] VEC [24] = '{
    {16'h8000, 3'd0, 1'b0}, {16'h8000, 3'd1, 1'b0}, {16'h8000, 3'd2, 1'b0}, {16'h8000, 3'd3, 1'b0},
    {16'h8000, 3'd4, 1'b1}, {16'h8000, 3'd5, 1'b1}, {16'h8000, 3'd6, 1'b1}, {16'h8000, 3'd7, 1'b1},
    {16'h0000, 3'd0, 1'b0}, {16'h0000, 3'd1, 1'b0}, {16'h0000, 3'd2, 1'b1}, {16'h0000, 3'd3, 1'b1},
    {16'h0000, 3'd4, 1'b0}, {16'h0000, 3'd5, 1'b0}, {16'h0000, 3'd6, 1'b1}, {16'h0000, 3'd7, 1'b1},
    {16'h0005, 3'd0, 1'b0}, {16'h0005, 3'd1, 1'b1}, {16'h0005, 3'd2, 1'b0}, {16'h0005, 3'd3, 1'b1},
    {16'h0005, 3'd4, 1'b0}, {16'h0005, 3'd5, 1'b1}, {16'h0005, 3'd6, 1'b0}, {16'h0005, 3'd7, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present a write-back on one edge, then drop loadEn
  task automatic writeBack(input logic [3:0] opc, input logic en, input logic [15:0] res);
    @(negedge clk);
    instr    = {opc, 12'h000};
    loadEn   = en;
    wbResult = res;
    @(negedge clk);
    loadEn   = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset flags", {13'd0, flags}, 16'h0002);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flags after release", {13'd0, flags}, 16'h0002);

    // R2 R3 R5: every mask against every flag state
    for (int i = 0; i < 24; i++) begin
      writeBack(4'b0001, 1'b1, VEC[i][19:4]);
      instr = {4'b0000, VEC[i][3:1], 9'h004};
      pcInc = 16'h3005;
      #1;
      check("R5 taken", {15'd0, brTaken}, {15'd0, VEC[i][0]});
      check("R8 nextPc", nextPc, VEC[i][0] ? 16'h3009 : 16'h3005);
    end

    // R2 R3: each flag-setting opcode
    writeBack(4'b0101, 1'b1, 16'hFFFF); check("R3 AND -> N", {13'd0, flags}, 16'h0004);
    writeBack(4'b1001, 1'b1, 16'h0000); check("R3 NOT -> Z", {13'd0, flags}, 16'h0002);
    writeBack(4'b0010, 1'b1, 16'h7FFF); check("R3 LD -> P",  {13'd0, flags}, 16'h0001);
    writeBack(4'b0110, 1'b1, 16'h8001); check("R3 LDR -> N", {13'd0, flags}, 16'h0004);
    writeBack(4'b1010, 1'b1, 16'h0000); check("R3 LDI -> Z", {13'd0, flags}, 16'h0002);
    writeBack(4'b1110, 1'b1, 16'h0001); check("R2 R3 LEA -> P", {13'd0, flags}, 16'h0001);

    // R4: non-setting opcodes and loadEn low leave P in place
    begin
      logic [3:0] quiet [7] = '{4'b0000, 4'b0011, 4'b0111, 4'b1011, 4'b1100, 4'b1101, 4'b1111};
      for (int q = 0; q < 7; q++) begin
        writeBack(quiet[q], 1'b1, 16'h0000);
        check("R4 quiet opcode holds", {13'd0, flags}, 16'h0001);
      end
    end
    writeBack(4'b0001, 1'b0, 16'h8000);
    check("R4 loadEn low holds", {13'd0, flags}, 16'h0001);

    // R6: non-branch opcode with mask bits set
    @(negedge clk);
    instr = {4'b0100, 3'b111, 9'h010};
    #1;
    check("R6 not a branch", {15'd0, brTaken}, 16'h0000);
    check("R6 nextPc", nextPc, pcInc);

    // R7: offset extremes
    @(negedge clk);
    pcInc = 16'h3000;
    instr = {4'b0000, 3'b111, 9'h0FF};
    #1;
    check("R7 +255", brTarget, 16'h30FF);
    check("R8 taken +255", nextPc, 16'h30FF);
    instr = {4'b0000, 3'b111, 9'h100};
    #1;
    check("R7 -256", brTarget, 16'h2F00);
    instr = {4'b0000, 3'b111, 9'h1FA};
    pcInc = 16'h300A;
    #1;
    check("R7 -6", brTarget, 16'h3004);
    pcInc = 16'hFFFF;
    instr = {4'b0000, 3'b000, 9'h002};
    #1;
    check("R7 wrap", brTarget, 16'h0001);
    check("R8 never taken", nextPc, 16'hFFFF);

    // R1: reset mid-run restores Z
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 async reset", {13'd0, flags}, 16'h0002);
    @(negedge clk);
    rstN = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule